// File: doc/BRIEF.md
# Interrupt Acceptance Controller

This block sits beside the sequencer of an 8-bit CPU core and decides, at each instruction boundary, whether the core takes a maskable interrupt, a non-maskable interrupt, or neither. The core tells the controller when an instruction ends. It also reports wait stalls, bus-request ownership, whether it is halted, and strobes from the instructions that enable or disable interrupts. The controller returns a one-cycle take pulse with the interrupt kind, the restart address, a request to push the program counter, and a request for an acknowledge cycle. It also returns a level that tells a halted core to resume.

The maskable request is active low and passes through a two-flop synchronizer. It is honoured only while the interrupt enable flag is set. The non-maskable request is active low and edge-sensitive. Its falling edge is held in a pending latch until it is accepted, so a short pulse arriving mid-instruction is not lost. The non-maskable request outranks the maskable one and ignores the enable flag. Two conditions block any acceptance: an active bus request, and a held wait stall, which keeps the instruction from ending.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, take_pulse, take_kind, restart_vec, push_pc, ack_cycle, halt_exit, ie_flag and ie_save are all 0. take_pulse is only asserted in the cycle after a clock edge at which end_of_instr was high.
- R2: A maskable request is accepted at a boundary edge (end_of_instr=1, stall=0, bus_req=0) when ie_flag=1. In the next cycle take_pulse=1, take_kind=2'b01, restart_vec=MASK_VEC (default 16'h0038), push_pc=1 and ack_cycle=1.
- R3: While ie_flag=0, a maskable request produces no take_pulse at a boundary.
- R4: A pending non-maskable request is accepted at a boundary whatever ie_flag is. The next cycle shows take_pulse=1, take_kind=2'b10, restart_vec=16'h0066, push_pc=1 and ack_cycle=0.
- R5: When both requests are present at the same boundary, the non-maskable one is taken.
- R6: A one-cycle low pulse on nmi_n between boundaries is held until the next boundary. Each falling edge is accepted once only.
- R7: While bus_req=1, no interrupt is taken. A request that was deferred this way is taken at the first later boundary with bus_req=0.
- R8: While stall=1, end_of_instr has no effect and no interrupt is taken.
- R9: Accepting a non-maskable request copies ie_flag into ie_save and clears ie_flag.
- R10: Accepting a maskable request clears ie_flag.
- R11: ie_set makes ie_flag 1 in the next cycle and ie_clr makes it 0. When both are strobed together, ie_clr wins.
- R12: halt_exit is 1 in the cycle after halted=1 coincides with a pending non-maskable request, or with a synchronized maskable request while ie_flag=1. It stays 0 for a maskable request while ie_flag=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Maskable request, active low, asynchronous |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive, asynchronous |
| bus_req | input | 1 | External bus request active; blocks acceptance |
| stall | input | 1 | Wait stall active; the instruction cannot end |
| end_of_instr | input | 1 | Strobe: current instruction is ending |
| ie_set | input | 1 | Strobe: set the interrupt enable flag |
| ie_clr | input | 1 | Strobe: clear the interrupt enable flag |
| halted | input | 1 | Core is in the halted state |
| take_pulse | output | 1 | One-cycle pulse: an interrupt was accepted |
| take_kind | output | 2 | 01 maskable, 10 non-maskable, 00 none |
| restart_vec | output | 16 | Restart address of the accepted interrupt |
| push_pc | output | 1 | Request to push the program counter |
| ack_cycle | output | 1 | Request an acknowledge cycle (I/O request with opcode fetch) |
| halt_exit | output | 1 | Halted core should resume |
| ie_flag | output | 1 | Interrupt enable flag |
| ie_save | output | 1 | Copy of the enable flag taken at non-maskable acceptance |

## Verification
All accept outputs appear one cycle after the boundary edge. The enable flag follows its strobes one cycle later, and halt_exit is due one cycle after its conditions meet. The maskable request counts only after two edges of synchronization, and a non-maskable edge is pending after three. The bench changes inputs on falling edges and samples on the falling edge that follows the boundary edge. For waits, it allows a few extra cycles before a boundary so that both request paths have settled. The scoreboard queues each expected take before the boundary is driven. The monitor pops an entry on every take pulse, and a pulse that arrives with an empty queue is a failure.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int VEC_W = 16;
  typedef enum logic [1:0] {
    TAKE_NONE = 2'b00,
    TAKE_MASK = 2'b01,
    TAKE_NMI  = 2'b10
  } take_kind_e;
endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q, stg_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_nxt = d;
    end else begin : g_many
      always_comb stg_nxt = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_nxt;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/nmi_edge_catch.sv
module nmi_edge_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_n,
  input  logic clear,
  output logic pend
);
  logic prev_q, pend_q;
  logic fall, pend_nxt;

  always_comb begin
    fall     = prev_q & ~lvl_n;
    pend_nxt = fall | (pend_q & ~clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_n;
      pend_q <= pend_nxt;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] MASK_VEC    = 16'h0038,
  parameter logic [VEC_W-1:0] NMI_VEC     = 16'h0066
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_n,
  input  logic             nmi_n,
  input  logic             bus_req,
  input  logic             stall,
  input  logic             end_of_instr,
  input  logic             ie_set,
  input  logic             ie_clr,
  input  logic             halted,
  output logic             take_pulse,
  output logic [1:0]       take_kind,
  output logic [VEC_W-1:0] restart_vec,
  output logic             push_pc,
  output logic             ack_cycle,
  output logic             halt_exit,
  output logic             ie_flag,
  output logic             ie_save
);
  logic irq_s_n, nmi_s_n, nmi_pend;
  logic boundary, irq_req, acc_nmi, acc_mask, acc_any;
  logic ie_q, ie_nxt, ie_en;
  logic save_q, save_nxt, save_en;
  logic take_q, take_nxt;
  take_kind_e kind_q, kind_nxt;
  logic [VEC_W-1:0] vec_q, vec_nxt;
  logic push_q, push_nxt, ack_q, ack_nxt, hexit_q, hexit_nxt;

  irq_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_n), .q(irq_s_n));

  irq_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
    .clk(clk), .rst_n(rst_n), .d(nmi_n), .q(nmi_s_n));

  nmi_edge_catch u_nmi_catch (
    .clk(clk), .rst_n(rst_n), .lvl_n(nmi_s_n), .clear(acc_nmi), .pend(nmi_pend));

  always_comb begin
    boundary = end_of_instr & ~stall & ~bus_req;
    irq_req  = ~irq_s_n;
    acc_nmi  = boundary & nmi_pend;
    acc_mask = boundary & ~nmi_pend & irq_req & ie_q;
    acc_any  = acc_nmi | acc_mask;

    ie_en = acc_any | ie_set | ie_clr;
    if (acc_any)     ie_nxt = 1'b0;
    else if (ie_clr) ie_nxt = 1'b0;
    else             ie_nxt = 1'b1;

    save_en  = acc_nmi;
    save_nxt = ie_q;

    take_nxt = acc_any;
    if (acc_nmi) begin
      kind_nxt = TAKE_NMI;
      vec_nxt  = NMI_VEC;
    end else if (acc_mask) begin
      kind_nxt = TAKE_MASK;
      vec_nxt  = MASK_VEC;
    end else begin
      kind_nxt = TAKE_NONE;
      vec_nxt  = '0;
    end
    push_nxt  = acc_any;
    ack_nxt   = acc_mask;
    hexit_nxt = halted & (nmi_pend | (irq_req & ie_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      save_q  <= 1'b0;
      take_q  <= 1'b0;
      kind_q  <= TAKE_NONE;
      vec_q   <= '0;
      push_q  <= 1'b0;
      ack_q   <= 1'b0;
      hexit_q <= 1'b0;
    end else begin
      if (ie_en)   ie_q   <= ie_nxt;
      if (save_en) save_q <= save_nxt;
      take_q  <= take_nxt;
      kind_q  <= kind_nxt;
      vec_q   <= vec_nxt;
      push_q  <= push_nxt;
      ack_q   <= ack_nxt;
      hexit_q <= hexit_nxt;
    end
  end

  assign take_pulse  = take_q;
  assign take_kind   = kind_q;
  assign restart_vec = vec_q;
  assign push_pc     = push_q;
  assign ack_cycle   = ack_q;
  assign halt_exit   = hexit_q;
  assign ie_flag     = ie_q;
  assign ie_save     = save_q;
endmodule

// File: rtl/irq_accept_ctrl_chk.sv
module irq_accept_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        stall,
  input logic        end_of_instr,
  input logic        take_pulse,
  input logic [1:0]  take_kind,
  input logic [15:0] restart_vec,
  input logic        push_pc,
  input logic        ack_cycle,
  input logic        ie_flag,
  input logic        ie_save
);
  // R1
  take_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> $past(end_of_instr));
  // R1
  take_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |=> !take_pulse);
  // R7
  busreq_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !take_pulse);
  // R8
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !take_pulse);
  // R4
  nmi_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse && take_kind == 2'b10) |-> (restart_vec == 16'h0066 && push_pc && !ack_cycle));
  // R2
  mask_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse && take_kind == 2'b01) |-> (push_pc && ack_cycle));
  // R10
  take_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> !ie_flag);
  // R9
  nmi_saves_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse && take_kind == 2'b10) |-> (ie_save == $past(ie_flag)));
endmodule

bind irq_accept_ctrl irq_accept_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .stall(stall),
  .end_of_instr(end_of_instr), .take_pulse(take_pulse), .take_kind(take_kind),
  .restart_vec(restart_vec), .push_pc(push_pc), .ack_cycle(ack_cycle),
  .ie_flag(ie_flag), .ie_save(ie_save));

// File: tb/test_irq_accept_ctrl.sv
module test_irq_accept_ctrl;
  logic clk = 1'b0;
  logic rst_n, irq_n, nmi_n, bus_req, stall, end_of_instr, ie_set, ie_clr, halted;
  logic take_pulse, push_pc, ack_cycle, halt_exit, ie_flag, ie_save;
  logic [1:0]  take_kind;
  logic [15:0] restart_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct packed { logic [1:0] kind; logic [15:0] vec; logic ack; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  irq_accept_ctrl i_irq_accept_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n), .bus_req(bus_req),
    .stall(stall), .end_of_instr(end_of_instr), .ie_set(ie_set), .ie_clr(ie_clr),
    .halted(halted), .take_pulse(take_pulse), .take_kind(take_kind),
    .restart_vec(restart_vec), .push_pc(push_pc), .ack_cycle(ack_cycle),
    .halt_exit(halt_exit), .ie_flag(ie_flag), .ie_save(ie_save));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every take pulse is compared against the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && take_pulse) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1 unexpected take", {30'd0, take_kind}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(take_kind == e.kind && restart_vec == e.vec && push_pc && ack_cycle == e.ack,
            (e.kind == 2'b10) ? "R4 R5 nmi take" : "R2 mask take",
            {take_kind, restart_vec, push_pc, ack_cycle}, {e.kind, e.vec, 1'b1, e.ack});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // boundary: if take expected, queue it; otherwise verify no pulse
  task automatic boundary(input bit exp_take, input logic [1:0] kind, input string tag);
    if (exp_take)
      sb.push_back({kind, (kind == 2'b10) ? 16'h0066 : 16'h0038, kind == 2'b01});
    end_of_instr = 1'b1;
    @(negedge clk);
    end_of_instr = 1'b0;
    if (!exp_take) chk(!take_pulse, tag, {31'd0, take_pulse}, 32'd0);
  endtask

  task automatic strobe_ie(input bit s, input bit c);
    ie_set = s; ie_clr = c;
    @(negedge clk);
    ie_set = 1'b0; ie_clr = 1'b0;
  endtask

  task automatic nmi_pulse();
    nmi_n = 1'b0;
    @(negedge clk);
    nmi_n = 1'b1;
    tick(5);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      chk(1'b0, "watchdog", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_n = 1'b1; nmi_n = 1'b1; bus_req = 1'b0; stall = 1'b0;
    end_of_instr = 1'b0; ie_set = 1'b0; ie_clr = 1'b0; halted = 1'b0;
    tick(3);
    // R1 reset state
    chk({take_pulse, take_kind, restart_vec, push_pc, ack_cycle, halt_exit, ie_flag, ie_save} == '0,
        "R1 reset", {take_pulse, take_kind, push_pc, ack_cycle, halt_exit, ie_flag, ie_save}, 32'd0);
    rst_n = 1'b1;
    tick(2);

    // R3 maskable ignored with ie_flag=0
    irq_n = 1'b0;
    tick(3);
    boundary(1'b0, 2'b00, "R3 masked irq");
    // R12 no exit while disabled
    halted = 1'b1; tick(2);
    chk(!halt_exit, "R12 halt exit disabled", {31'd0, halt_exit}, 32'd0);

    // R11 enable strobes
    strobe_ie(1'b1, 1'b0);
    chk(ie_flag, "R11 set", {31'd0, ie_flag}, 32'd1);
    strobe_ie(1'b1, 1'b1);
    chk(!ie_flag, "R11 clr wins", {31'd0, ie_flag}, 32'd0);
    strobe_ie(1'b1, 1'b0);
    tick(1);
    // R12 halted with enabled maskable request
    chk(halt_exit, "R12 halt exit irq", {31'd0, halt_exit}, 32'd1);
    halted = 1'b0;

    // R7 bus request defers, then R2 acceptance
    bus_req = 1'b1;
    boundary(1'b0, 2'b00, "R7 busreq blocks irq");
    bus_req = 1'b0;
    // R8 stall defers
    stall = 1'b1;
    boundary(1'b0, 2'b00, "R8 stall blocks irq");
    stall = 1'b0;
    boundary(1'b1, 2'b01, "R2");
    // R10 acceptance cleared enable
    chk(!ie_flag, "R10 ie cleared", {31'd0, ie_flag}, 32'd0);
    irq_n = 1'b1;
    tick(3);

    // R4 R9 nmi with ie=1, short pulse held (R6)
    strobe_ie(1'b1, 1'b0);
    nmi_pulse();
    halted = 1'b1; tick(1);
    chk(halt_exit, "R12 halt exit nmi", {31'd0, halt_exit}, 32'd1);
    halted = 1'b0;
    boundary(1'b1, 2'b10, "R4");
    chk(!ie_flag && ie_save, "R9 save and clear", {30'd0, ie_flag, ie_save}, 32'd1);
    // R6 accepted once per edge
    boundary(1'b0, 2'b00, "R6 single acceptance");

    // R4 nmi with ie=0
    nmi_pulse();
    boundary(1'b1, 2'b10, "R4 ie off");
    chk(!ie_save, "R9 save zero", {31'd0, ie_save}, 32'd0);

    // R5 priority, then maskable after re-enable
    strobe_ie(1'b1, 1'b0);
    irq_n = 1'b0;
    nmi_pulse();
    boundary(1'b1, 2'b10, "R5");
    strobe_ie(1'b1, 1'b0);
    boundary(1'b1, 2'b01, "R5 mask after nmi");
    irq_n = 1'b1;
    tick(3);

    // R7 bus request overrides pending nmi
    nmi_pulse();
    bus_req = 1'b1;
    boundary(1'b0, 2'b00, "R7 busreq blocks nmi");
    boundary(1'b0, 2'b00, "R7 busreq blocks nmi again");
    bus_req = 1'b0;
    boundary(1'b1, 2'b10, "R7 deferred nmi");
    tick(3);

    chk(sb.size() == 0, "R2 R4 scoreboard drained", sb.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule